// File: doc/BRIEF.md
# Three-Wire Serial DAC Code Loader

This block takes 16-bit converter codes from a host over three synchronous wires: a serial clock, a serial data line and a latch strobe. All three are sampled by the block's own system clock through two-flop synchronizers. Bits enter a shift register, most significant bit first, on each rising edge of the serial clock. The shift register is copied into the holding register that drives the converter only when the latch line rises. Between latches the converter keeps its value while new words are shifted in.

The bit leaving the top of the shift register is driven onto a serial output, and that output changes only while the serial clock is low. Several loaders can therefore share one clock and one latch in a chain: each word shifts into the next device while the following word enters this one. An asynchronous clear input and the reset both put the converter at the bottom of the selected output range. A two-bit range select maps the held code onto a common output level scale on which all ones stands for 24 mA.

Top module: `serial_dac_loader`

## Requirements
- R1: After reset, `at_floor` is 1, `dac_code` is 0, `sdo` is 0 and `loop_level` is the floor of the selected range.
- R2: `dac_code` changes only on a rising edge of `latch`, which loads it with the last 16 bits shifted in. Shifting alone leaves it unchanged.
- R3: Bits are taken from `sdi` on rising `sclk` edges, most significant bit first, so the last bit shifted becomes bit 0.
- R4: `sdo` carries the top bit of the shift register and changes only while `sclk` is low. While the next 16 bits shift in, the 16 values seen on `sdo` at the rising edges are the previously shifted word, MSB first.
- R5: While `latch` is high, `sclk` edges do not shift the register.
- R6: While `clr` is high, `at_floor` is 1 and `dac_code` is 0, with no clock edge needed. After `clr` falls, this state holds until the next latch strobe.
- R7: If `clr` is high when `latch` rises, the clear wins: `at_floor` stays 1.
- R8: Clear does not alter the shift register. A later latch strobe with no new shifting loads the word shifted before the clear.
- R9: `loop_level` = base + floor(`dac_code` × span / 65536). `range_sel` 00 (4–20 mA) gives base 10922 and span 43690. 01 (0–20 mA) gives base 0 and span 54613. 10 (0–24 mA) gives base 0 and span 65536. 11 is treated as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data input |
| latch | input | 1 | Transfer strobe, active on rising edge |
| clr | input | 1 | Asynchronous clear to range floor, active high |
| range_sel | input | 2 | Output range select |
| sdo | output | 1 | Serial data output for chaining |
| dac_code | output | 16 | Code presented to the converter |
| loop_level | output | 16 | Output level on a 0–24 mA full scale |
| at_floor | output | 1 | High while the output is forced to the range floor |

## Verification
The assertions assume that `sclk`, `latch` and `sdi` change slowly compared with `clk`, so every level lasts several system clocks after synchronization. They also assume that `clr` never moves right at a `clk` edge. The bench keeps each serial half period and each latch phase at six system clocks, and it changes all inputs a few nanoseconds after a rising edge. Random words and ranges come from a fixed seed. Directed sequences cover a clear that coincides with a latch, clock edges during a latch, and reuse of the shift register after a clear.

// File: rtl/serial_dac_loader.sv
module serial_dac_loader #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         latch,
  input  logic         clr,
  input  logic [1:0]   range_sel,
  output logic         sdo,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] loop_level,
  output logic         at_floor
);

  localparam longint FS      = longint'(1) << W;
  localparam longint BASE_LO = FS / 6;
  localparam longint SPAN_LO = (FS * 2) / 3;
  localparam longint SPAN_20 = (FS * 5) / 6;

  logic [SYNC-1:0] sclk_p, sdi_p, lat_p;
  logic            sclk_d, lat_d;
  logic [W-1:0]    shreg, hold_q;
  logic            floor_q, sdo_q;
  logic [W-1:0]    base;
  logic [W:0]      span;
  logic [2*W:0]    prod;

  wire sclk_s    = sclk_p[SYNC-1];
  wire sdi_s     = sdi_p[SYNC-1];
  wire lat_s     = lat_p[SYNC-1];
  wire sclk_rise = sclk_s & ~sclk_d;
  wire lat_rise  = lat_s & ~lat_d;
  wire force_fl  = clr | ~rst_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sdi_p  <= '0;
      lat_p  <= '0;
      sclk_d <= 1'b0;
      lat_d  <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[SYNC-2:0], sclk};
      sdi_p  <= {sdi_p[SYNC-2:0], sdi};
      lat_p  <= {lat_p[SYNC-2:0], latch};
      sclk_d <= sclk_s;
      lat_d  <= lat_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      sdo_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (sclk_rise && !lat_s) shreg <= {shreg[W-2:0], sdi_s};
      if (!sclk_s) sdo_q <= shreg[W-1];
      if (lat_rise && !clr) hold_q <= shreg;
    end

  always_ff @(posedge clk or posedge force_fl)
    if (force_fl) floor_q <= 1'b1;
    else if (lat_rise) floor_q <= 1'b0;

  always_comb begin
    case (range_sel)
      2'b01:   begin base = '0; span = (W+1)'(SPAN_20); end
      2'b10:   begin base = '0; span = (W+1)'(FS); end
      default: begin base = W'(BASE_LO); span = (W+1)'(SPAN_LO); end
    endcase
  end

  assign dac_code   = floor_q ? '0 : hold_q;
  assign prod       = dac_code * span;
  assign loop_level = base + prod[2*W-1:W];
  assign at_floor   = floor_q;
  assign sdo        = sdo_q;

  a_r2_hold_only_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(hold_q));
  a_r4_sdo_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_s |=> $stable(sdo_q));
  a_r5_no_shift_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
    lat_s |=> $stable(shreg));
  a_r6_clear_floor: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (at_floor && dac_code == '0));
  a_r6_floor_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (at_floor && !lat_rise) |=> at_floor);
  a_r9_level_above_base: assert property (@(posedge clk) disable iff (!rst_n)
    loop_level >= base);

endmodule

// File: tb/tb_serial_dac_loader.sv
module tb_serial_dac_loader;
  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, latch = 0, clr = 0;
  logic [1:0]  range_sel = 2'b00;
  logic        sdo, at_floor;
  logic [15:0] dac_code, loop_level;
  int errors = 0, checks = 0;
  logic [15:0] exp_sh = 0, exp_hold = 0, cap;
  logic        exp_floor = 1;

  serial_dac_loader dut (.clk, .rst_n, .sclk, .sdi, .latch, .clr, .range_sel,
                         .sdo, .dac_code, .loop_level, .at_floor);

  always #5 clk = ~clk;

  function automatic logic [15:0] lvl(input logic [1:0] r, input logic [15:0] c);
    longint b, s;
    case (r)
      2'b01:   begin b = 0;     s = 54613; end
      2'b10:   begin b = 0;     s = 65536; end
      default: begin b = 10922; s = 43690; end
    endcase
    return 16'(b + (longint'(c) * s) / 65536);
  endfunction

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [15:0] w, output logic [15:0] got);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      wt(6);
      got[i] = sdo;
      sclk = 1;
      if (!latch) exp_sh = {exp_sh[14:0], w[i]};
      wt(6);
      sclk = 0;
    end
    wt(6);
  endtask

  task automatic strobe();
    latch = 1; wt(6);
    if (!clr) begin exp_hold = exp_sh; exp_floor = 0; end
    latch = 0; wt(6);
  endtask

  task automatic check_out(string req);
    chk(req, {15'd0, at_floor}, {15'd0, exp_floor});
    chk(req, dac_code, exp_floor ? 16'd0 : exp_hold);
    chk(req, loop_level, lvl(range_sel, exp_floor ? 16'd0 : exp_hold));
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w, prev;
    void'($urandom(32'd1234));
    wt(3); rst_n = 1; wt(3);
    check_out("R1 reset");
    chk("R1 sdo", {15'd0, sdo}, 16'd0);

    // R3, R4: first word shifts out zeros, then chaining
    prev = 16'hA5C3;
    shift_word(prev, cap);
    chk("R4 chain first", cap, 16'h0000);
    check_out("R2 no load without latch");
    strobe();
    check_out("R3 msb first load");
    for (int k = 0; k < 24; k++) begin
      w = 16'($urandom);
      range_sel = 2'($urandom);
      shift_word(w, cap);
      chk("R4 chain", cap, prev);
      check_out("R2 held while shifting");
      if (k % 3 != 2) strobe();
      check_out("R9 level after latch");
      prev = w;
    end

    // R9 corners
    shift_word(16'hFFFF, cap); strobe();
    for (int r = 0; r < 4; r++) begin range_sel = 2'(r); wt(1); check_out("R9 full scale"); end
    prev = 16'hFFFF;

    // R5: clock edges during latch are ignored
    latch = 1; wt(6);
    shift_word(16'h1234, cap);
    latch = 0; wt(6);
    strobe();
    chk("R5 no shift in latch", dac_code, prev);

    // R6: clear, held and released
    shift_word(16'h3C3C, cap); strobe();
    range_sel = 2'b00;
    wt(1); clr = 1; exp_floor = 1; #3;
    chk("R6 clear immediate", {15'd0, at_floor}, 16'd1);
    wt(4); check_out("R6 clear held");
    clr = 0; wt(8); check_out("R6 after release");

    // R8: shift register survives clear
    strobe();
    chk("R8 reload after clear", dac_code, 16'h3C3C);

    // R7: clear wins over simultaneous latch
    shift_word(16'h0F0F, cap);
    clr = 1; exp_floor = 1; latch = 1; wt(8);
    latch = 0; wt(6); clr = 0; wt(6);
    check_out("R7 clear priority");
    strobe();
    chk("R8 latch after priority", dac_code, 16'h0F0F);
    check_out("R9 level");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule